// File: doc/BRIEF.md
# Pseudo-SRAM Power Sequencer

This block owns the power-state handling of a pseudo-SRAM that has an active-low sleep pin. Once the supply is reported good, it keeps the chip select forced high for a start-up wait. Only after that wait does it tell the access controller that the memory may be used. From then on it accepts one-cycle requests to put the memory into deep sleep and to wake it again.

On a wake request the sequencer raises the sleep pin and then runs a long recovery wait before it reports ready again. The memory cells are not refreshed while the part sleeps. For that reason, every departure from deep sleep raises a sticky contents-lost flag. The flag stays set until the access controller acknowledges it.

Requests that arrive at the wrong moment are dropped, and each one produces a one-cycle error pulse. The waits are parameters counted in clock cycles. A parameter removes deep sleep for memories that have no sleep pin.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is asserted, and right after it is released, the outputs are: `pwrState` = 0, `csHoldHigh` = 1, `sleepN` = 1, `memReady` = 0, `dataLost` = 0 and `cmdError` = 0.
- R2: In the wait state (code 0), the state becomes ready (code 1) on the STARTUP_CYCLES-th consecutive rising edge at which `supplyGood` is sampled high. Any edge that samples `supplyGood` low restarts the count.
- R3: The outputs are decoded from `pwrState` as follows:
  - wait (0) and recover (3): `csHoldHigh`=1, `sleepN`=1, `memReady`=0.
  - ready (1): `csHoldHigh`=0, `sleepN`=1, `memReady`=1.
  - sleep (2): `csHoldHigh`=1, `sleepN`=0, `memReady`=0.
- R4: An `enterReq` sampled in the ready state moves the block to sleep (2) after that edge.
- R5: An `exitReq` in sleep is taken only once `sleepN` has been low for at least MIN_SLEEP_CYCLES edges. The block then moves to recover (3). An earlier `exitReq` leaves the block in sleep.
- R6: The recover state becomes ready on its RECOVERY_CYCLES-th edge.
- R7: `dataLost` is set on every edge that leaves the sleep state, and `lossAck` clears it. When both happen on the same edge, setting wins.
- R8: Any of these requests changes nothing else and raises `cmdError` for exactly the cycle after the edge that sampled it:
  - `enterReq` outside ready.
  - `exitReq` outside sleep.
  - `exitReq` that R5 refuses.
- R9: `supplyGood` sampled low in any state sends the block to the wait state after that edge.
- R10: With SLEEP_PIN_PRESENT = 0, `sleepN` stays 1 at all times and every `enterReq` is rejected as described in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| supplyGood | input | 1 | Supply at or above its minimum level |
| enterReq | input | 1 | One-cycle request to enter deep sleep |
| exitReq | input | 1 | One-cycle request to leave deep sleep |
| lossAck | input | 1 | Clears the contents-lost flag |
| csHoldHigh | output | 1 | Forces the memory chip select inactive (high) |
| sleepN | output | 1 | Level for the memory's active-low sleep pin |
| memReady | output | 1 | Accesses are allowed |
| dataLost | output | 1 | Memory contents must be treated as invalid |
| cmdError | output | 1 | Pulse: a request was rejected |
| pwrState | output | 2 | 0 wait, 1 ready, 2 sleep, 3 recover |

## Verification
Some properties are checked by assertions on every cycle:
- the sleep pin is never low while chip select is released;
- ready never rises before a full wait of supply-good cycles has passed;
- the sleep pin never rises early while the supply is good;
- the contents-lost flag only rises when sleep is left;
- the pin stays high when the pin is absent.

Other behaviour can only be shown by the bench's scenarios: the exact edge counts of the start-up and recovery waits, the restart of the start-up wait after a supply glitch, rejection of early and misplaced commands with their single-cycle error pulses, and the set-over-acknowledge priority.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

  typedef enum logic [1:0] {
    PWR_WAIT    = 2'd0,
    PWR_READY   = 2'd1,
    PWR_SLEEP   = 2'd2,
    PWR_RECOVER = 2'd3
  } pwrState_t;

  typedef struct packed {
    logic cntClear;
    logic setLost;
    logic reject;
  } ctrlStrobes_t;

endpackage

// File: rtl/psram_pwr_dp.sv
module psram_pwr_dp
  import psram_pwr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic             lossAck,
  output logic [CNT_W-1:0] cnt,
  output logic             dataLost,
  output logic             cmdError
);

  // Saturating wait counter, cleared on every state change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 cnt <= '0;
    else if (strobes.cntClear) cnt <= '0;
    else if (cnt != '1)        cnt <= cnt + 1'b1;
  end

  // Sticky contents-lost flag: set has priority over acknowledge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                dataLost <= 1'b0;
    else if (strobes.setLost) dataLost <= 1'b1;
    else if (lossAck)         dataLost <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cmdError <= 1'b0;
    else       cmdError <= strobes.reject;
  end

  assert_lost_set_wins_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.setLost) |-> dataLost);

  assert_error_follows_reject_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.reject |=> cmdError);

endmodule

// File: rtl/psram_pwr_ctrl.sv
module psram_pwr_ctrl
  import psram_pwr_pkg::*;
#(
  parameter int CNT_W             = 8,
  parameter int STARTUP_CYCLES    = 16,
  parameter int RECOVERY_CYCLES   = 16,
  parameter int MIN_SLEEP_CYCLES  = 2,
  parameter bit SLEEP_PIN_PRESENT = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             supplyGood,
  input  logic             enterReq,
  input  logic             exitReq,
  input  logic [CNT_W-1:0] cnt,
  output ctrlStrobes_t     strobes,
  output pwrState_t        state,
  output logic             csHoldHigh,
  output logic             sleepN,
  output logic             memReady
);

  localparam logic [CNT_W-1:0] START_LAST   = CNT_W'(STARTUP_CYCLES - 1);
  localparam logic [CNT_W-1:0] RECOVER_LAST = CNT_W'(RECOVERY_CYCLES - 1);
  localparam logic [CNT_W-1:0] SLEEP_LAST   = CNT_W'(MIN_SLEEP_CYCLES - 1);

  pwrState_t nextState;
  logic      enterOk;
  logic      exitOk;

  assign enterOk = SLEEP_PIN_PRESENT && supplyGood && (state == PWR_READY);
  assign exitOk  = supplyGood && (state == PWR_SLEEP) && (cnt >= SLEEP_LAST);

  always_comb begin
    nextState        = state;
    strobes.cntClear = 1'b0;
    strobes.setLost  = 1'b0;
    strobes.reject   = (enterReq && !enterOk) || (exitReq && !exitOk);
    if (!supplyGood) begin
      nextState        = PWR_WAIT;
      strobes.cntClear = 1'b1;
      strobes.setLost  = (state == PWR_SLEEP);
    end else begin
      unique case (state)
        PWR_WAIT: if (cnt >= START_LAST) begin
          nextState        = PWR_READY;
          strobes.cntClear = 1'b1;
        end
        PWR_READY: if (enterReq && enterOk) begin
          nextState        = PWR_SLEEP;
          strobes.cntClear = 1'b1;
        end
        PWR_SLEEP: if (exitReq && exitOk) begin
          nextState        = PWR_RECOVER;
          strobes.cntClear = 1'b1;
          strobes.setLost  = 1'b1;
        end
        PWR_RECOVER: if (cnt >= RECOVER_LAST) begin
          nextState        = PWR_READY;
          strobes.cntClear = 1'b1;
        end
        default: begin
          nextState        = PWR_WAIT;
          strobes.cntClear = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PWR_WAIT;
    else       state <= nextState;
  end

  // Pin controls straight from the state register
  assign memReady   = (state == PWR_READY);
  assign csHoldHigh = (state != PWR_READY);
  assign sleepN     = (state != PWR_SLEEP);

  assert_sleep_entry_from_ready_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == PWR_SLEEP) && ($past(state) != PWR_SLEEP) |-> $past(enterReq));

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_pwr_pkg::*;
#(
  parameter int STARTUP_CYCLES    = 20000,
  parameter int RECOVERY_CYCLES   = 20000,
  parameter int MIN_SLEEP_CYCLES  = 2,
  parameter bit SLEEP_PIN_PRESENT = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       supplyGood,
  input  logic       enterReq,
  input  logic       exitReq,
  input  logic       lossAck,
  output logic       csHoldHigh,
  output logic       sleepN,
  output logic       memReady,
  output logic       dataLost,
  output logic       cmdError,
  output logic [1:0] pwrState
);

  localparam int MAX_AB   = (STARTUP_CYCLES > RECOVERY_CYCLES) ? STARTUP_CYCLES : RECOVERY_CYCLES;
  localparam int MAX_WAIT = (MAX_AB > MIN_SLEEP_CYCLES) ? MAX_AB : MIN_SLEEP_CYCLES;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int MIN_WAIT = (STARTUP_CYCLES < RECOVERY_CYCLES) ? STARTUP_CYCLES : RECOVERY_CYCLES;

  ctrlStrobes_t     strobes;
  pwrState_t        state;
  logic [CNT_W-1:0] cnt;

  psram_pwr_ctrl #(
    .CNT_W            (CNT_W),
    .STARTUP_CYCLES   (STARTUP_CYCLES),
    .RECOVERY_CYCLES  (RECOVERY_CYCLES),
    .MIN_SLEEP_CYCLES (MIN_SLEEP_CYCLES),
    .SLEEP_PIN_PRESENT(SLEEP_PIN_PRESENT)
  ) ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .supplyGood(supplyGood),
    .enterReq  (enterReq),
    .exitReq   (exitReq),
    .cnt       (cnt),
    .strobes   (strobes),
    .state     (state),
    .csHoldHigh(csHoldHigh),
    .sleepN    (sleepN),
    .memReady  (memReady)
  );

  psram_pwr_dp #(.CNT_W(CNT_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .lossAck (lossAck),
    .cnt     (cnt),
    .dataLost(dataLost),
    .cmdError(cmdError)
  );

  assign pwrState = state;

  // Checker-side run counters (independent of the sequencer counter)
  logic [31:0] waitRun;
  logic [31:0] lowRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitRun <= '0;
      lowRun  <= '0;
    end else begin
      waitRun <= (csHoldHigh && sleepN && supplyGood) ? ((waitRun == '1) ? waitRun : waitRun + 1) : '0;
      lowRun  <= !sleepN ? ((lowRun == '1) ? lowRun : lowRun + 1) : '0;
    end
  end

  assert_cs_high_while_asleep_R3: assert property (@(posedge clk) disable iff (!rstN)
    !sleepN |-> csHoldHigh && !memReady);

  assert_ready_after_wait_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReady) |-> waitRun >= 32'(MIN_WAIT));

  assert_min_sleep_width_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepN) && $past(supplyGood) |-> lowRun >= 32'(MIN_SLEEP_CYCLES));

  assert_lost_only_leaving_sleep_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataLost) |-> $past(state) == PWR_SLEEP);

  generate
    if (!SLEEP_PIN_PRESENT) begin : g_noPin
      assert_pin_never_low_R10: assert property (@(posedge clk) disable iff (!rstN)
        sleepN && (state != PWR_SLEEP));
    end
  endgenerate

endmodule

// File: tb/psram_pwr_seq_tb_top.sv
module psram_pwr_seq_tb_top;

  localparam int T = 10;  // start-up edges
  localparam int R = 8;   // recovery edges
  localparam int M = 4;   // minimum sleep edges
  localparam logic [1:0] S_W = 2'd0, S_R = 2'd1, S_S = 2'd2, S_C = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supplyGood = 1'b0, enterReq = 1'b0, exitReq = 1'b0, lossAck = 1'b0;

  logic aCs, aSlp, aRdy, aLost, aErr;
  logic [1:0] aSt;
  logic bCs, bSlp, bRdy, bLost, bErr;
  logic [1:0] bSt;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  psram_pwr_seq #(.STARTUP_CYCLES(T), .RECOVERY_CYCLES(R), .MIN_SLEEP_CYCLES(M),
                  .SLEEP_PIN_PRESENT(1'b1)) dut_i (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .enterReq(enterReq),
    .exitReq(exitReq), .lossAck(lossAck), .csHoldHigh(aCs), .sleepN(aSlp),
    .memReady(aRdy), .dataLost(aLost), .cmdError(aErr), .pwrState(aSt));

  psram_pwr_seq #(.STARTUP_CYCLES(T), .RECOVERY_CYCLES(R), .MIN_SLEEP_CYCLES(M),
                  .SLEEP_PIN_PRESENT(1'b0)) dut_nopin_i (
    .clk(clk), .rstN(rstN), .supplyGood(supplyGood), .enterReq(enterReq),
    .exitReq(exitReq), .lossAck(lossAck), .csHoldHigh(bCs), .sleepN(bSlp),
    .memReady(bRdy), .dataLost(bLost), .cmdError(bErr), .pwrState(bSt));

  typedef struct {
    string      tag;
    bit         isB;
    logic [1:0] st;
    logic       lost;
    logic       err;
  } expItem_t;

  expItem_t expQ[$];

  // Driver: drive after the falling edge, expect the outputs after the next rising edge
  task automatic step(input logic e, input logic x, input logic a, input logic sg,
                      input string tag, input logic [1:0] st, input logic lost,
                      input logic err, input bit chkB = 1'b0,
                      input logic [1:0] bs = 2'd0, input logic be = 1'b0);
    @(negedge clk);
    enterReq = e; exitReq = x; lossAck = a; supplyGood = sg;
    expQ.push_back('{tag, 1'b0, st, lost, err});
    if (chkB) expQ.push_back('{tag, 1'b1, bs, 1'b0, be});
  endtask

  // Monitor: pop and compare a few ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #3;
      while (expQ.size() > 0) begin
        expItem_t it;
        logic [1:0] gs;
        logic gc, gp, gr, gl, ge, ec, ep, er;
        it = expQ.pop_front();
        if (it.isB) begin gs = bSt; gc = bCs; gp = bSlp; gr = bRdy; gl = bLost; ge = bErr; end
        else        begin gs = aSt; gc = aCs; gp = aSlp; gr = aRdy; gl = aLost; ge = aErr; end
        ec = (it.st != S_R);  // R3 table
        ep = (it.st != S_S);
        er = (it.st == S_R);
        compared++;
        if ({gs, gc, gp, gr, gl, ge} !== {it.st, ec, ep, er, it.lost, it.err}) begin
          mismatched++;
          $display("FAIL %s dut%s: got st=%0d cs=%b slp=%b rdy=%b lost=%b err=%b, expected st=%0d cs=%b slp=%b rdy=%b lost=%b err=%b",
                   it.tag, it.isB ? "B" : "A", gs, gc, gp, gr, gl, ge,
                   it.st, ec, ep, er, it.lost, it.err);
        end
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset state, both variants
    step(0, 0, 0, 0, "R1", S_W, 0, 0, 1, S_W, 0);
    step(0, 0, 0, 0, "R1", S_W, 0, 0, 1, S_W, 0);
    @(negedge clk) rstN = 1'b1;
    step(0, 0, 0, 0, "R1", S_W, 0, 0, 1, S_W, 0);
    // R2: power-up wait; R8: enter during the wait is rejected
    for (int i = 1; i <= T; i++)
      step(i == 3, 0, 0, 1, (i == 3) ? "R8" : "R2", (i == T) ? S_R : S_W, 0, i == 3,
           1, (i == T) ? S_R : S_W, i == 3);
    step(0, 1, 0, 1, "R8", S_R, 0, 1, 1, S_R, 1);   // exit while ready
    step(0, 0, 1, 1, "R7", S_R, 0, 0);              // ack with nothing pending
    step(1, 0, 0, 1, "R4", S_S, 0, 0, 1, S_R, 1);   // A sleeps; R10: B rejects
    step(0, 1, 0, 1, "R5", S_S, 0, 1);              // exit too early
    step(1, 0, 0, 1, "R8", S_S, 0, 1);              // enter while asleep
    step(0, 0, 0, 1, "R8", S_S, 0, 0);              // error lasted one cycle
    step(0, 1, 0, 1, "R5", S_C, 1, 0);              // exit after M edges, R7 lost set
    for (int i = 1; i <= R; i++)
      step(i == 2, 0, 0, 1, (i == 2) ? "R8" : "R6", (i == R) ? S_R : S_C, 1, i == 2);
    step(0, 0, 1, 1, "R7", S_R, 0, 0);              // ack clears
    step(0, 0, 0, 0, "R9", S_W, 0, 0, 1, S_W, 0);   // supply loss from ready
    step(0, 0, 0, 0, "R9", S_W, 0, 0);
    for (int i = 1; i <= 5; i++) step(0, 0, 0, 1, "R2", S_W, 0, 0);
    step(0, 0, 0, 0, "R2", S_W, 0, 0);              // glitch restarts the count
    for (int i = 1; i <= T; i++)
      step(0, 0, 0, 1, "R2", (i == T) ? S_R : S_W, 0, 0, i == T, S_R, 0);
    step(1, 0, 0, 1, "R4", S_S, 0, 0, 1, S_R, 1);
    for (int k = 1; k <= M - 1; k++) step(0, 0, 0, 1, "R5", S_S, 0, 0);
    step(0, 1, 1, 1, "R7", S_C, 1, 0);              // set beats simultaneous ack
    step(0, 0, 0, 1, "R6", S_C, 1, 0);
    step(0, 0, 0, 0, "R9", S_W, 1, 0);              // supply loss from recover
    for (int i = 1; i <= T; i++)
      step(0, 0, 0, 1, "R2", (i == T) ? S_R : S_W, 1, 0);
    step(0, 0, 1, 1, "R7", S_R, 0, 0);
    step(1, 0, 0, 1, "R4", S_S, 0, 0, 1, S_R, 1);
    step(0, 0, 0, 0, "R9", S_W, 1, 0, 1, S_W, 0);   // supply loss from sleep sets lost
    step(0, 0, 0, 0, "R10", S_W, 1, 0, 1, S_W, 0);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule